// File: doc/BRIEF.md
# Microcode Sequencer with Opcode Dispatch

This block is the control sequencer of a microcoded stack processor that runs 8-bit opcodes. A 9-bit microprogram counter selects one 36-bit microword out of a 512-entry control store. The word at the current counter value is shown on the outputs at once. Its control fields are also broken out as separate signals for the datapath, which is outside this block.

At each clock edge the sequencer picks the next microaddress. The sources are: the following address in sequence, an unconditional branch, a branch on one of three datapath conditions (opcode not cached, A is zero, A is negative), or a dispatch on the current opcode. The dispatch sends each class of opcode to a fixed entry point. The immediate class is split by an immediate-continuation flag. The sequencer also holds that flag and an interrupt-active flag. At the fetch-next entry point, a pending interrupt diverts the sequence to the interrupt entry point.

A load port writes words into the control store, so the microprogram can be filled or replaced for test.

Top module: `ucode_sequencer`

## Requirements
- R1: While reset is held and in the first cycle after its release, the microprogram counter reads 474 and both flags read 0.
- R2: The field outputs always equal slices of the word on `uword`:
  - read select = bit 0
  - ALU-B select = bits 2..1
  - address select = bits 4..3
  - ALU operation = bits 8..5
  - register writes (SP, PC, A, B in ascending bit order) = bits 12..9
  - opcode write = bit 15
  - memory read = bit 17
  - memory write = bit 18
  - constant field = bits 25..19
  - load-A-from-memory = bit 30
  - byte access = bit 31
  - halfword access = bit 32
- R3: When no branch, dispatch or interrupt applies, the counter advances by one. It wraps from 511 to 0.
- R4: Bit 26 set makes the next address the constant field shifted left by two (field × 4). This branch outranks the conditional branches and the dispatch.
- R5: Each condition branches to the same target (field × 4), and the condition branches together outrank the dispatch:
  - bit 27 with `op_miss` high
  - bit 28 with `a_zero` high
  - bit 29 with `a_neg` high
- R6: When bits 27 and 16 are both set, the sequencer branches to field × 4 if `op_miss` is high. Otherwise it performs the opcode dispatch.
- R7: Bit 16 set, with no branch taken, dispatches on the opcode as follows:
  - 010xxxxx goes to 493
  - 011xxxxx goes to 496
  - 0001xxxx goes to 500
  - 001xxxxx goes to 504
  - 0000xxxx goes to the opcode × 4, so breakpoint 0x00 goes to 0
- R8: A dispatch of an opcode 1xxxxxxx goes to 488 when the continuation flag is 0, and to 491 when it is 1.
- R9: The continuation flag is set by bit 13 and cleared by bit 14. Clear wins when both are set. A dispatch uses the flag value from before the current word updates it.
- R10: The interrupt-active flag is set by bit 35 and cleared by bit 34. Clear wins when both are set.
- R11: When the counter is at 480, the interrupt-active flag is 0 and `irq_pend` is high, the next address is 484, regardless of the microword.
- R12: A word written through the load port at an address appears on `uword` whenever the counter holds that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Control-store write enable |
| ld_addr | input | 9 | Control-store write address |
| ld_data | input | 36 | Control-store write data |
| opcode | input | 8 | Current opcode for dispatch |
| op_miss | input | 1 | Opcode at PC is not cached |
| a_zero | input | 1 | Register A is zero |
| a_neg | input | 1 | Register A is negative |
| irq_pend | input | 1 | Interrupt request pending |
| upc | output | 9 | Microprogram counter |
| uword | output | 36 | Current microword |
| cont_flag | output | 1 | Immediate-continuation flag |
| int_active | output | 1 | Interrupt-active flag |
| rd_sel | output | 1 | Read-path select |
| alub_sel | output | 2 | ALU-B select |
| addr_sel | output | 2 | Address select |
| alu_op | output | 4 | ALU operation |
| reg_wr | output | 4 | Register writes, bit 0 SP to bit 3 B |
| op_wr | output | 1 | Opcode write |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| const_fld | output | 7 | Address/constant field |
| ld_a_mem | output | 1 | Load A from memory data |
| byte_acc | output | 1 | Byte access |
| half_acc | output | 1 | Halfword access |

## Verification
`uword` and every field output follow `upc` in the same cycle, because the control store is read combinationally. The counter and both flags change one clock edge after the microword and inputs that select them.

The bench drives inputs just after a falling edge and predicts the next state from its own copy of the store. It then samples all outputs at the following falling edge, half a period after the rising edge that updates them.

Load-port writes are done under reset and checked later, when the counter reaches those addresses.

// File: rtl/ucseq_pkg.sv
package ucseq_pkg;
    localparam int UA_W  = 9;
    localparam int UW_W  = 36;
    localparam int OP_W  = 8;
    localparam int FLD_W = 7;
    localparam int DEPTH = 1 << UA_W;

    localparam logic [UA_W-1:0] ENT_RESET    = 9'd474;
    localparam logic [UA_W-1:0] ENT_FETCH    = 9'd476;
    localparam logic [UA_W-1:0] ENT_NEXT     = 9'd480;
    localparam logic [UA_W-1:0] ENT_INT      = 9'd484;
    localparam logic [UA_W-1:0] ENT_IM_FIRST = 9'd488;
    localparam logic [UA_W-1:0] ENT_IM_MORE  = 9'd491;
    localparam logic [UA_W-1:0] ENT_STSP     = 9'd493;
    localparam logic [UA_W-1:0] ENT_LDSP     = 9'd496;
    localparam logic [UA_W-1:0] ENT_ADDSP    = 9'd500;
    localparam logic [UA_W-1:0] ENT_EMUL     = 9'd504;

    localparam int B_RDSEL  = 0;
    localparam int B_ALUB   = 1;
    localparam int B_ADSEL  = 3;
    localparam int B_ALU    = 5;
    localparam int B_REGW   = 9;
    localparam int B_CSET   = 13;
    localparam int B_CCLR   = 14;
    localparam int B_OPW    = 15;
    localparam int B_DEC    = 16;
    localparam int B_MRD    = 17;
    localparam int B_MWR    = 18;
    localparam int B_FLD    = 19;
    localparam int B_BR     = 26;
    localparam int B_BMISS  = 27;
    localparam int B_BZERO  = 28;
    localparam int B_BNEG   = 29;
    localparam int B_LDA    = 30;
    localparam int B_BYTE   = 31;
    localparam int B_HALF   = 32;
    localparam int B_IEXIT  = 34;
    localparam int B_IENTER = 35;

    typedef struct packed {
        logic [UA_W-1:0] upc;
        logic            cont;
        logic            intact;
    } seq_state_t;
endpackage

// File: rtl/ucseq_store.sv
module ucseq_store #(
    parameter int AW = 9,
    parameter int DW = 36
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int N = 1 << AW;

    logic [DW-1:0] mem_q [N];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/ucseq_dispatch.sv
module ucseq_dispatch
    import ucseq_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    input  logic            cont,
    output logic [UA_W-1:0] entry
);
    always_comb begin
        casez (opcode)
            8'b1???????: entry = cont ? ENT_IM_MORE : ENT_IM_FIRST;
            8'b010?????: entry = ENT_STSP;
            8'b011?????: entry = ENT_LDSP;
            8'b001?????: entry = ENT_EMUL;
            8'b0001????: entry = ENT_ADDSP;
            default:     entry = UA_W'({opcode[3:0], 2'b00});
        endcase
    end
endmodule

// File: rtl/ucode_sequencer.sv
module ucode_sequencer
    import ucseq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_en,
    input  logic [8:0]       ld_addr,
    input  logic [35:0]      ld_data,
    input  logic [7:0]       opcode,
    input  logic             op_miss,
    input  logic             a_zero,
    input  logic             a_neg,
    input  logic             irq_pend,
    output logic [8:0]       upc,
    output logic [35:0]      uword,
    output logic             cont_flag,
    output logic             int_active,
    output logic             rd_sel,
    output logic [1:0]       alub_sel,
    output logic [1:0]       addr_sel,
    output logic [3:0]       alu_op,
    output logic [3:0]       reg_wr,
    output logic             op_wr,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic [6:0]       const_fld,
    output logic             ld_a_mem,
    output logic             byte_acc,
    output logic             half_acc
);
    seq_state_t      st_q, st_d;
    logic [UW_W-1:0] word;
    logic [UA_W-1:0] disp_entry;
    logic [UA_W-1:0] br_tgt;
    logic            cond_hit;
    logic            irq_take;

    ucseq_store #(.AW(UA_W), .DW(UW_W)) u_store (
        .clk     (clk),
        .wr_en   (ld_en),
        .wr_addr (ld_addr),
        .wr_data (ld_data),
        .rd_addr (st_q.upc),
        .rd_data (word)
    );

    ucseq_dispatch u_disp (
        .opcode (opcode),
        .cont   (st_q.cont),
        .entry  (disp_entry)
    );

    always_comb begin
        br_tgt   = UA_W'({word[B_FLD +: FLD_W], 2'b00});
        cond_hit = (word[B_BMISS] && op_miss) || (word[B_BZERO] && a_zero) ||
                   (word[B_BNEG] && a_neg);
        irq_take = (st_q.upc == ENT_NEXT) && !st_q.intact && irq_pend;
        st_d     = st_q;

        if (irq_take) begin
            st_d.upc = ENT_INT;
        end else if (word[B_BR] || cond_hit) begin
            st_d.upc = br_tgt;
        end else if (word[B_DEC]) begin
            st_d.upc = disp_entry;
        end else begin
            st_d.upc = st_q.upc + 1'b1;
        end

        if (word[B_CCLR]) begin
            st_d.cont = 1'b0;
        end else if (word[B_CSET]) begin
            st_d.cont = 1'b1;
        end

        if (word[B_IEXIT]) begin
            st_d.intact = 1'b0;
        end else if (word[B_IENTER]) begin
            st_d.intact = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{upc: ENT_RESET, cont: 1'b0, intact: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign upc        = st_q.upc;
    assign uword      = word;
    assign cont_flag  = st_q.cont;
    assign int_active = st_q.intact;
    assign rd_sel     = word[B_RDSEL];
    assign alub_sel   = word[B_ALUB +: 2];
    assign addr_sel   = word[B_ADSEL +: 2];
    assign alu_op     = word[B_ALU +: 4];
    assign reg_wr     = word[B_REGW +: 4];
    assign op_wr      = word[B_OPW];
    assign mem_rd     = word[B_MRD];
    assign mem_wr     = word[B_MWR];
    assign const_fld  = word[B_FLD +: FLD_W];
    assign ld_a_mem   = word[B_LDA];
    assign byte_acc   = word[B_BYTE];
    assign half_acc   = word[B_HALF];

    // R1
    reset_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (upc == ENT_RESET && !cont_flag && !int_active));

    // R3
    seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_take && !uword[B_BR] && !cond_hit && !uword[B_DEC])
        |=> upc == 9'($past(upc) + 9'd1));

    // R4
    branch_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uword[B_BR] && !irq_take) |=> upc == {$past(const_fld), 2'b00});

    // R8
    imm_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_take && !uword[B_BR] && !cond_hit && uword[B_DEC] && opcode[7] && !cont_flag)
        |=> upc == ENT_IM_FIRST);

    // R10
    int_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uword[B_IENTER] && !uword[B_IEXIT]) |=> int_active);

    // R11
    irq_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upc == ENT_NEXT && !int_active && irq_pend) |=> upc == ENT_INT);
endmodule

// File: tb/ucode_sequencer_test.sv
module ucode_sequencer_test;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_en = 1'b0;
    logic [8:0]  ld_addr = '0;
    logic [35:0] ld_data = '0;
    logic [7:0]  opcode = '0;
    logic        op_miss = 1'b0, a_zero = 1'b0, a_neg = 1'b0, irq_pend = 1'b0;
    logic [8:0]  upc;
    logic [35:0] uword;
    logic        cont_flag, int_active, rd_sel, op_wr, mem_rd, mem_wr;
    logic        ld_a_mem, byte_acc, half_acc;
    logic [1:0]  alub_sel, addr_sel;
    logic [3:0]  alu_op, reg_wr;
    logic [6:0]  const_fld;

    logic [35:0] img [512];
    logic [8:0]  e_upc;
    logic        e_cont, e_int;
    string       e_tag;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    ucode_sequencer uut (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
        .opcode(opcode), .op_miss(op_miss), .a_zero(a_zero), .a_neg(a_neg),
        .irq_pend(irq_pend), .upc(upc), .uword(uword), .cont_flag(cont_flag),
        .int_active(int_active), .rd_sel(rd_sel), .alub_sel(alub_sel),
        .addr_sel(addr_sel), .alu_op(alu_op), .reg_wr(reg_wr), .op_wr(op_wr),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .const_fld(const_fld), .ld_a_mem(ld_a_mem),
        .byte_acc(byte_acc), .half_acc(half_acc)
    );

    function automatic logic [8:0] disp_m(logic [7:0] op, logic c);
        if (op[7])               return c ? 9'd491 : 9'd488;
        if (op[7:5] == 3'b010)   return 9'd493;
        if (op[7:5] == 3'b011)   return 9'd496;
        if (op[7:5] == 3'b001)   return 9'd504;
        if (op[7:4] == 4'b0001)  return 9'd500;
        return {3'b000, op[3:0], 2'b00};
    endfunction

    function automatic logic [31:0] fields_of(logic [35:0] w);
        return {5'b0, w[0], w[2:1], w[4:3], w[8:5], w[12:9], w[15], w[17], w[18],
                w[25:19], w[30], w[31], w[32]};
    endfunction

    task automatic chk(string tag, string what, logic [35:0] got, logic [35:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got %0h exp %0h", tag, what, got, exp);
        end
    endtask

    task automatic check_outputs();
        chk(e_tag, "upc", 36'(upc), 36'(e_upc));
        chk("R9", "cont_flag", 36'(cont_flag), 36'(e_cont));
        chk("R10", "int_active", 36'(int_active), 36'(e_int));
        chk("R12", "uword", uword, img[e_upc]);
        chk("R2", "fields",
            36'({5'b0, rd_sel, alub_sel, addr_sel, alu_op, reg_wr, op_wr, mem_rd, mem_wr,
                 const_fld, ld_a_mem, byte_acc, half_acc}),
            36'(fields_of(img[e_upc])));
    endtask

    task automatic predict();
        logic [35:0] w;
        logic        hit;
        w   = img[e_upc];
        hit = (w[27] && op_miss) || (w[28] && a_zero) || (w[29] && a_neg);
        if (e_upc == 9'd480 && !e_int && irq_pend) begin
            e_upc = 9'd484; e_tag = "R11";
        end else if (w[26]) begin
            e_upc = {w[25:19], 2'b00}; e_tag = "R4";
        end else if (hit) begin
            e_upc = {w[25:19], 2'b00}; e_tag = (w[27] && w[16]) ? "R6" : "R5";
        end else if (w[16]) begin
            e_tag = opcode[7] ? "R8" : "R7";
            e_upc = disp_m(opcode, e_cont);
        end else begin
            e_upc = e_upc + 9'd1; e_tag = "R3";
        end
        if (w[14])      e_cont = 1'b0;
        else if (w[13]) e_cont = 1'b1;
        if (w[34])      e_int = 1'b0;
        else if (w[35]) e_int = 1'b1;
    endtask

    task automatic load_word(int a, logic [35:0] w);
        @(negedge clk);
        ld_en = 1'b1; ld_addr = 9'(a); ld_data = w; img[a] = w;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic restart();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        e_upc = 9'd474; e_cont = 1'b0; e_int = 1'b0; e_tag = "R1";
        check_outputs();
        rst_n = 1'b1;
    endtask

    task automatic step();
        predict();
        @(negedge clk);
        check_outputs();
    endtask

    function automatic logic [35:0] rand_word();
        logic [35:0] w;
        w = {$urandom(), $urandom()};
        w[26] = ($urandom_range(0, 5) == 0);
        w[27] = ($urandom_range(0, 3) == 0);
        w[28] = ($urandom_range(0, 5) == 0);
        w[29] = ($urandom_range(0, 5) == 0);
        return w;
    endfunction

    function automatic logic [35:0] br_word(logic [6:0] f, logic [35:0] extra);
        return extra | (36'd1 << 26) | (36'(f) << 19);
    endfunction

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        // R12: fill the control store through the load port while in reset
        for (int a = 0; a < 512; a++) load_word(a, rand_word());
        // word 511 steps so that the counter wraps to 0 (R3)
        load_word(511, 36'h0_0000_0000);
        load_word(510, br_word(7'd127, 36'h0));
        restart();
        for (int i = 0; i < 3000; i++) begin
            opcode   = 8'($urandom());
            op_miss  = 1'($urandom());
            a_zero   = 1'($urandom());
            a_neg    = 1'($urandom());
            irq_pend = 1'($urandom());
            step();
        end

        // R11 then R10 then R8: 474 -> 480 -> 484 (enter int) -> 480 -> decode
        load_word(474, br_word(7'd120, 36'h0));
        load_word(480, 36'd1 << 16);
        load_word(484, br_word(7'd120, 36'd1 << 35));
        restart();
        opcode = 8'h80; op_miss = 0; a_zero = 0; a_neg = 0; irq_pend = 1'b1;
        repeat (4) step();

        // R9 and R8: set continuation at 474, dispatch immediate -> 491
        load_word(474, br_word(7'd120, 36'd1 << 13));
        load_word(480, 36'd1 << 16);
        restart();
        irq_pend = 1'b0; opcode = 8'hC5;
        repeat (2) step();

        // R6: miss with decode branches; no miss dispatches
        load_word(480, (36'd1 << 27) | (36'd1 << 16) | (36'(7'd5) << 19));
        for (int m = 0; m < 2; m++) begin
            load_word(474, br_word(7'd120, 36'h0));
            restart();
            op_miss = 1'(m); opcode = 8'h48;
            repeat (2) step();
        end

        // R7: each class and breakpoint
        load_word(480, 36'd1 << 16);
        op_miss = 1'b0;
        foreach (img[k]) if (k < 7) begin
            logic [7:0] ops [7] = '{8'h00, 8'h0D, 8'h1F, 8'h25, 8'h41, 8'h7E, 8'hFF};
            restart();
            opcode = ops[k];
            repeat (2) step();
        end

        // R10: clear wins over set
        load_word(474, br_word(7'd121, (36'd1 << 35) | (36'd1 << 34) |
                                       (36'd1 << 13) | (36'd1 << 14)));
        restart();
        step();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule